// File: doc/BRIEF.md
# Serial Management Target with Preamble Suppression

This block is the PHY side of a two-wire serial management link. The management clock `mdc` is its only clock. On every rising edge it samples the data line and parses management frames of the usual clause-22 shape. A frame carries a two-bit start pattern, a two-bit operation code, the target's five-bit address, a five-bit register number and a two-bit turnaround. Sixteen data bits follow, most significant first. Frames whose address equals the `phy_addr` strap are served. A read makes the block drive the register contents back on the line. A write updates a small register file and also pulses an address/data strobe for the rest of the PHY.

After a hardware reset, or a software reset through the control register, the block accepts nothing until it has seen an unbroken run of `PREAMBLE_LEN` one-bits. From then on, one idle high bit between frames is enough for it to find the next start. A fixed bit in the status register tells the management master that the per-frame preamble can be dropped. The line pull-up is external. The block only produces an output value and an output enable.

Top module: `mdio_mgmt_target`

## Requirements
- R1: While `rst_n` is low and directly after reset, `mdio_oe` and `wr_stb` are 0.
- R2: After reset, frames are ignored until at least `PREAMBLE_LEN` (32) consecutive 1 bits have been sampled. A run of 31 ones followed by a frame gives no drive and no strobe, and the frame changes no register.
- R3: A matching read frame is bits 0,1 (start), then opcode 1,0, PA[4:0], RA[4:0], and two turnaround bits. The first turnaround bit is released. The target drives 0 in the second turnaround bit and then RA's contents, bit 15 first, one bit per `mdc` cycle. Each value appears on the clock edge that samples the previous bit. The line is released after bit 0.
- R4: A matching write frame (opcode 0,1, turnaround 1,0, then 16 data bits MSB first) never enables `mdio_oe`. It raises `wr_stb` for exactly one cycle, starting at the edge that samples the last data bit, with `wr_addr`=RA and `wr_data`=the data word. The register is then updated.
- R5: A frame whose address differs from `phy_addr` is parsed to its end, drives nothing, strobes nothing and changes no register.
- R6: Opcodes 0,0 and 1,1 are invalid. Such a frame is dropped, and the target waits for a high idle bit and a new start.
- R7: Once initialised, a single idle 1 bit between the last data bit of one frame and the next start bit is enough.
- R8: Register 1 is the status register. It reads as `STATUS_BASE` with bit 6 forced to 1 to advertise preamble suppression, and writes leave it unchanged.
- R9: Writing register 0 with bit 15 set is a software reset. It clears every writable register to 0 and requires a fresh `PREAMBLE_LEN`-bit preamble. Register 0 bit 15 reads as 0.
- R10: Register numbers at or above `NUM_REGS` read as 0, and writes to them store nothing. They still present `wr_stb`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mdc | input | 1 | Management clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| phy_addr | input | 5 | Address strap compared against the frame's address field |
| mdio_i | input | 1 | Sampled level of the management data line |
| mdio_o | output | 1 | Value driven onto the data line when enabled |
| mdio_oe | output | 1 | Output enable for the data line; 0 leaves it to the pull-up |
| wr_stb | output | 1 | One-cycle write strobe for a matching write frame |
| wr_addr | output | 5 | Register number of the last matching write |
| wr_data | output | 16 | Data word of the last matching write |

## Verification
The bench uses the default parameters: eight registers, a 32-bit preamble, and a status base with bit 6 clear. With these values, register number 10 lies above the file, and the forced suppression bit is the only source of bit 6 in a status read. A 31-versus-32 run of ones sits exactly at the preamble threshold. A software reset followed by a 32-bit run exercises re-initialisation within a few hundred clock cycles.

// File: rtl/mdio_mgmt_target.sv
`timescale 1ns/1ps
module mdio_mgmt_target #(
  parameter int          NUM_REGS     = 8,
  parameter int          PREAMBLE_LEN = 32,
  parameter logic [15:0] STATUS_BASE  = 16'h7809
) (
  input  logic        mdc,
  input  logic        rst_n,
  input  logic [4:0]  phy_addr,
  input  logic        mdio_i,
  output logic        mdio_o,
  output logic        mdio_oe,
  output logic        wr_stb,
  output logic [4:0]  wr_addr,
  output logic [15:0] wr_data
);
  localparam int PCW = $clog2(PREAMBLE_LEN + 1);
  localparam int IW  = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam logic [5:0] NREG = 6'(NUM_REGS);
  localparam logic [4:0] CTRL_ADDR = 5'd0;
  localparam logic [4:0] STAT_ADDR = 5'd1;
  localparam int SUPPRESS_BIT = 6;
  localparam int SRST_BIT = 15;

  typedef enum logic [2:0] {IDLE, START, OPC, PHYA, REGA, TURN, DATA, WAITHI} st_t;

  st_t            st;
  logic [3:0]     bcnt;
  logic           pre_ok;
  logic [PCW-1:0] pre_cnt;
  logic [1:0]     op;
  logic [4:0]     pa, ra;
  logic [15:0]    sh, rd_sh, rd_val;
  logic [15:0]    regs [NUM_REGS];

  wire        hit     = (pa == phy_addr);
  wire        is_rd   = (op == 2'b10);
  wire        is_wr   = (op == 2'b01);
  wire [15:0] wdata   = {sh[14:0], mdio_i};
  wire        last_wr = (st == DATA) && (bcnt == 4'd15) && is_wr && hit;
  wire        srst    = last_wr && (ra == CTRL_ADDR) && wdata[SRST_BIT];

  always_comb begin
    if (ra == STAT_ADDR)
      rd_val = STATUS_BASE | (16'd1 << SUPPRESS_BIT);
    else if ({1'b0, ra} < NREG)
      rd_val = regs[ra[IW-1:0]];
    else
      rd_val = '0;
  end

  always_ff @(posedge mdc or negedge rst_n) begin
    if (!rst_n) begin
      st      <= IDLE;
      bcnt    <= '0;
      pre_ok  <= 1'b0;
      pre_cnt <= '0;
      op      <= '0;
      pa      <= '0;
      ra      <= '0;
      sh      <= '0;
    end else begin
      case (st)
        IDLE: begin
          if (!pre_ok) begin
            if (mdio_i) begin
              if (pre_cnt == PCW'(PREAMBLE_LEN - 1)) pre_ok <= 1'b1;
              else pre_cnt <= pre_cnt + 1'b1;
            end else begin
              pre_cnt <= '0;
            end
          end else if (!mdio_i) begin
            st <= START;
          end
        end
        START: begin
          bcnt <= '0;
          st   <= mdio_i ? OPC : WAITHI;
        end
        OPC: begin
          op <= {op[0], mdio_i};
          if (bcnt == 4'd1) begin
            bcnt <= '0;
            st   <= (op[0] ^ mdio_i) ? PHYA : WAITHI;
          end else begin
            bcnt <= bcnt + 1'b1;
          end
        end
        PHYA: begin
          pa <= {pa[3:0], mdio_i};
          if (bcnt == 4'd4) begin
            bcnt <= '0;
            st   <= REGA;
          end else begin
            bcnt <= bcnt + 1'b1;
          end
        end
        REGA: begin
          ra <= {ra[3:0], mdio_i};
          if (bcnt == 4'd4) begin
            bcnt <= '0;
            st   <= TURN;
          end else begin
            bcnt <= bcnt + 1'b1;
          end
        end
        TURN: begin
          if (bcnt == 4'd1) begin
            bcnt <= '0;
            st   <= DATA;
          end else begin
            bcnt <= bcnt + 1'b1;
          end
        end
        DATA: begin
          sh <= wdata;
          if (bcnt == 4'd15) begin
            bcnt <= '0;
            if (srst) begin
              st      <= IDLE;
              pre_ok  <= 1'b0;
              pre_cnt <= '0;
            end else begin
              st <= WAITHI;
            end
          end else begin
            bcnt <= bcnt + 1'b1;
          end
        end
        default: begin
          if (mdio_i) st <= IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge mdc or negedge rst_n) begin
    if (!rst_n) begin
      wr_stb  <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= '0;
    end else begin
      wr_stb <= last_wr;
      if (last_wr) begin
        wr_addr <= ra;
        wr_data <= wdata;
      end
      if (srst) begin
        for (int i = 0; i < NUM_REGS; i++) regs[i] <= '0;
      end else if (last_wr) begin
        for (int i = 0; i < NUM_REGS; i++) begin
          if (ra == 5'(i) && ra != STAT_ADDR)
            regs[i] <= (ra == CTRL_ADDR) ? (wdata & 16'h7fff) : wdata;
        end
      end
    end
  end

  always_ff @(posedge mdc or negedge rst_n) begin
    if (!rst_n) begin
      mdio_oe <= 1'b0;
      mdio_o  <= 1'b0;
      rd_sh   <= '0;
    end else if (st == TURN && bcnt == 4'd0 && is_rd && hit && pre_ok) begin
      mdio_oe <= 1'b1;
      mdio_o  <= 1'b0;
    end else if (st == TURN && bcnt == 4'd1 && mdio_oe) begin
      mdio_o <= rd_val[15];
      rd_sh  <= {rd_val[14:0], 1'b0};
    end else if (st == DATA && mdio_oe) begin
      if (bcnt == 4'd15) begin
        mdio_oe <= 1'b0;
        mdio_o  <= 1'b0;
      end else begin
        mdio_o <= rd_sh[15];
        rd_sh  <= {rd_sh[14:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/mdio_mgmt_target_chk.sv
`timescale 1ns/1ps
module mdio_mgmt_target_chk (
  input logic mdc,
  input logic rst_n,
  input logic mdio_oe,
  input logic mdio_o,
  input logic wr_stb,
  input logic pre_ok
);
  logic [4:0] oe_run;

  always_ff @(posedge mdc or negedge rst_n) begin
    if (!rst_n) oe_run <= '0;
    else if (!mdio_oe) oe_run <= '0;
    else if (oe_run != 5'd31) oe_run <= oe_run + 1'b1;
  end

  assert_uninit_quiet_R2: assert property (@(posedge mdc) disable iff (!rst_n)
    !pre_ok |-> !mdio_oe);
  assert_turn_zero_R3: assert property (@(posedge mdc) disable iff (!rst_n)
    $rose(mdio_oe) |-> !mdio_o);
  assert_drive_len_R3: assert property (@(posedge mdc) disable iff (!rst_n)
    $fell(mdio_oe) |-> oe_run == 5'd17);
  assert_drive_max_R3: assert property (@(posedge mdc) disable iff (!rst_n)
    oe_run <= 5'd17);
  assert_strobe_pulse_R4: assert property (@(posedge mdc) disable iff (!rst_n)
    wr_stb |=> !wr_stb);
  assert_strobe_quiet_R4: assert property (@(posedge mdc) disable iff (!rst_n)
    wr_stb |-> !mdio_oe);
  assert_srst_strobe_R9: assert property (@(posedge mdc) disable iff (!rst_n)
    $fell(pre_ok) |-> wr_stb);
endmodule

bind mdio_mgmt_target mdio_mgmt_target_chk u_chk (
  .mdc(mdc), .rst_n(rst_n), .mdio_oe(mdio_oe), .mdio_o(mdio_o),
  .wr_stb(wr_stb), .pre_ok(pre_ok)
);

// File: tb/mdio_mgmt_target_tb.sv
`timescale 1ns/1ps
module mdio_mgmt_target_tb;
  localparam logic [4:0]  PHY    = 5'h0C;
  localparam logic [4:0]  OTHER  = 5'h03;
  localparam logic [15:0] STATUS = 16'h7809 | 16'h0040;

  logic mdc = 1'b0;
  logic rst_n = 1'b0;
  logic mb = 1'b1;
  logic mdio_i, mdio_o, mdio_oe, wr_stb;
  logic [4:0]  wr_addr;
  logic [15:0] wr_data;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  bit pre_seen = 0;
  int ones_run = 0;
  logic [15:0] mreg [8];

  always #10 mdc = ~mdc;
  assign mdio_i = mdio_oe ? mdio_o : mb;

  mdio_mgmt_target u_dut (
    .mdc(mdc), .rst_n(rst_n), .phy_addr(PHY), .mdio_i(mdio_i),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .wr_stb(wr_stb),
    .wr_addr(wr_addr), .wr_data(wr_data)
  );

  function automatic logic [15:0] model_read(input logic [4:0] ra);
    if (ra == 5'd1) return STATUS;
    if (ra < 5'd8) return mreg[ra[2:0]];
    return 16'h0000;
  endfunction

  task automatic slot(input logic b, input logic eoe, input logic eo,
                      input logic ewr, input logic [4:0] ewa,
                      input logic [15:0] ewd, input string req);
    @(negedge mdc);
    compared++;
    if (mdio_oe !== eoe || (eoe && mdio_o !== eo)) begin
      mismatched++;
      $display("FAIL %s line: oe=%b o=%b expected oe=%b o=%b", req, mdio_oe, mdio_o, eoe, eo);
    end
    compared++;
    if (wr_stb !== ewr || (ewr && (wr_addr !== ewa || wr_data !== ewd))) begin
      mismatched++;
      $display("FAIL %s strobe: stb=%b addr=%h data=%h expected stb=%b addr=%h data=%h",
               req, wr_stb, wr_addr, wr_data, ewr, ewa, ewd);
    end
    mb = b;
    if (!pre_seen) begin
      if (b) begin
        ones_run++;
        if (ones_run >= 32) pre_seen = 1;
      end else begin
        ones_run = 0;
      end
    end
  endtask

  task automatic line(input logic b, input int n, input string req);
    for (int i = 0; i < n; i++) slot(b, 1'b0, 1'b0, 1'b0, 5'd0, 16'd0, req);
  endtask

  task automatic frame(input logic [1:0] op, input logic [4:0] pa, input logic [4:0] ra,
                       input logic [15:0] wd, input int idles, input string req);
    logic rd, wr, hit;
    logic [15:0] rv;
    logic [31:0] fr;
    rd  = (op == 2'b10);
    wr  = (op == 2'b01);
    hit = pre_seen && (pa == PHY);
    rv  = model_read(ra);
    fr  = {2'b01, op, pa, ra, (rd ? 2'b11 : 2'b10), (rd ? 16'hFFFF : wd)};
    for (int j = 0; j < 32; j++)
      slot(fr[31-j], hit && rd && j >= 15, (j == 15) ? 1'b0 : rv[31-j],
           1'b0, 5'd0, 16'd0, req);
    if (hit && wr) begin
      if (ra == 5'd0 && wd[15]) begin
        for (int i = 0; i < 8; i++) mreg[i] = 16'h0000;
        pre_seen = 0;
        ones_run = 0;
      end else if (ra != 5'd1 && ra < 5'd8) begin
        mreg[ra[2:0]] = (ra == 5'd0) ? (wd & 16'h7fff) : wd;
      end
    end
    slot(1'b1, 1'b0, 1'b0, hit && wr, ra, wd, req);
    line(1'b1, idles - 1, req);
  endtask

  task automatic bad_op(input logic [1:0] op, input string req);
    slot(1'b0, 1'b0, 1'b0, 1'b0, 5'd0, 16'd0, req);
    slot(1'b1, 1'b0, 1'b0, 1'b0, 5'd0, 16'd0, req);
    slot(op[1], 1'b0, 1'b0, 1'b0, 5'd0, 16'd0, req);
    slot(op[0], 1'b0, 1'b0, 1'b0, 5'd0, 16'd0, req);
    line(1'b1, 3, req);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) mreg[i] = 16'h0000;
    repeat (3) begin
      @(negedge mdc);
      compared++;
      if (mdio_oe !== 1'b0 || wr_stb !== 1'b0) begin
        mismatched++;
        $display("FAIL R1 reset: oe=%b stb=%b expected oe=0 stb=0", mdio_oe, wr_stb);
      end
    end
    rst_n = 1'b1;
    line(1'b1, 2, "R1");

    frame(2'b01, PHY, 5'd2, 16'h1230, 1, "R2 before preamble");
    line(1'b0, 1, "R2");
    line(1'b1, 31, "R2");
    frame(2'b01, PHY, 5'd2, 16'h5550, 1, "R2 after 31 ones");
    line(1'b0, 1, "R2");
    line(1'b1, 32, "R2");
    frame(2'b10, PHY, 5'd2, 16'h0, 1, "R2 read back");

    frame(2'b01, PHY, 5'd2, 16'hA5C3, 1, "R4 write");
    frame(2'b10, PHY, 5'd2, 16'h0, 1, "R3 R7 read");
    frame(2'b01, PHY, 5'd3, 16'hFFFF, 1, "R4 write ones");
    frame(2'b10, PHY, 5'd3, 16'h0, 3, "R3 read ones");
    frame(2'b10, PHY, 5'd1, 16'h0, 1, "R8 status");
    frame(2'b01, PHY, 5'd1, 16'h0000, 1, "R8 write status");
    frame(2'b10, PHY, 5'd1, 16'h0, 1, "R8 status unchanged");

    frame(2'b01, OTHER, 5'd2, 16'h0F0F, 1, "R5 foreign write");
    frame(2'b10, OTHER, 5'd2, 16'h0, 1, "R5 foreign read");
    frame(2'b10, PHY, 5'd2, 16'h0, 1, "R5 reg kept");

    bad_op(2'b00, "R6 op 00");
    bad_op(2'b11, "R6 op 11");
    frame(2'b10, PHY, 5'd3, 16'h0, 1, "R6 after invalid");

    frame(2'b01, PHY, 5'd10, 16'hBEEF, 1, "R10 write high reg");
    frame(2'b10, PHY, 5'd10, 16'h0, 1, "R10 read high reg");

    frame(2'b01, PHY, 5'd0, 16'h0123, 1, "R9 ctrl write");
    frame(2'b10, PHY, 5'd0, 16'h0, 1, "R9 ctrl read");
    frame(2'b01, PHY, 5'd0, 16'h8000, 1, "R9 soft reset");
    frame(2'b10, PHY, 5'd2, 16'h0, 1, "R9 ignored after reset");
    line(1'b0, 1, "R9");
    line(1'b1, 32, "R9");
    frame(2'b10, PHY, 5'd2, 16'h0, 1, "R9 cleared reg");
    frame(2'b10, PHY, 5'd0, 16'h0, 1, "R9 ctrl cleared");
    frame(2'b10, PHY, 5'd1, 16'h0, 1, "R8 status after reset");

    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    #(20ns * 200000);
    if (!done) begin
      done = 1;
      mismatched++;
      $display("FAIL watchdog: run did not complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule